// File: doc/BRIEF.md
# SRAM Chip-Enable Write Protector

This block sits between a processor's memory chip-enable and a static RAM. It keeps the RAM from taking stray writes while the main supply collapses. While supply is good, the gated enable tracks the processor's enable within the same cycle.

When a supply-fail flag is raised, what happens depends on the bus. If the memory is idle, its enable is locked inactive. If a memory access is under way, that access may run to its natural end, bounded by a cycle-count timeout, and the lock then engages. The lock holds until the fail flag drops. A status output reports when the lock is engaged.

The fail flag is treated as asynchronous and passes through a configurable synchronizer. The reset input is asserted asynchronously and its release is synchronized inside the block.

Top module: `cewp_guard`

## Requirements
- R1: During reset and right after it, `protect` is 0 and `ce_out_n` equals `ce_in_n`.
- R2: While the synchronized fail flag has been low at the last clock edge, `ce_out_n` equals `ce_in_n` in the same cycle.
- R3: A rise of `pwr_fail` takes effect at the SYNC_STAGES+1-th rising clock edge after it is applied. Before that edge, the output still follows the input.
- R4: If `ce_in_n` is 1 at the edge where the fail is acted on, `protect` goes to 1 and `ce_out_n` to 1 at that edge.
- R5: If `ce_in_n` is 0 at that edge, the access is held: `ce_out_n` stays 0 and `protect` stays 0 while `ce_in_n` stays 0, for up to HOLD_CYCLES cycles.
- R6: During a hold, a rise of `ce_in_n` drives `ce_out_n` to 1 in the same cycle, and `protect` goes to 1 at the next clock edge.
- R7: A hold lasts at most HOLD_CYCLES clock cycles. At the next edge, `protect` goes to 1 and `ce_out_n` to 1 even if `ce_in_n` is still 0.
- R8: While `protect` is 1, `ce_out_n` is 1 whatever `ce_in_n` does.
- R9: Once `pwr_fail` falls, `protect` drops at the SYNC_STAGES+1-th rising edge after the fall, and from then on `ce_out_n` follows `ce_in_n`.
- R10: If `pwr_fail` falls during a hold, the block returns to following the input with no lock and no timeout, at the SYNC_STAGES+1-th edge after the fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in_n | input | 1 | Processor chip-enable, active low |
| pwr_fail | input | 1 | Supply below trip point when 1, asynchronous |
| ce_out_n | output | 1 | Gated chip-enable to the RAM, active low |
| protect | output | 1 | 1 while write protection is locked |

## Verification
The enable is exercised with several patterns:

- **Toggling, no fail:** the enable toggles with the fail flag low, to show same-cycle tracking.
- **Fail while idle:** this shows the immediate lock, and that input activity is ignored while locked.
- **Fail during an access, enable released:** this separates release by the enable from release by the timeout.
- **Fail during an access, enable held low:** this hits the timeout exactly at its last cycle and at the following cycle.
- **Fail cleared mid-access:** this separates a return to tracking from a lock.

Each fail rise and fall is sampled one edge before and at the edge where it takes effect, which pins down the synchronizer latency.

// File: rtl/cewp_pkg.sv
package cewp_pkg;
  typedef enum logic [1:0] {
    ST_PASS = 2'd0,  // enable tracks the processor
    ST_HOLD = 2'd1,  // fail seen during an access, letting it finish
    ST_LOCK = 2'd2   // enable forced inactive
  } cewp_state_e;
endpackage

// File: rtl/cewp_sync.sv
module cewp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      logic s_d;
      always_comb s_d = d;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= s_d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      logic [STAGES-1:0] sr_d;
      always_comb sr_d = {sr_q[STAGES-2:0], d};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
      end
      assign q = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cewp_timer.sv
module cewp_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [W-1:0] START = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? START : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cewp_fsm.sv
module cewp_fsm
  import cewp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic fail_s,
  input  logic expired,
  output logic load,
  output logic run,
  output logic ce_out_n,
  output logic protect
);
  cewp_state_e state_q;
  cewp_state_e state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ST_PASS: begin
        if (fail_s) begin
          if (!ce_in_n) begin
            state_d = ST_HOLD;
            load    = 1'b1;
          end else begin
            state_d = ST_LOCK;
          end
        end
      end
      ST_HOLD: begin
        if (!fail_s)      state_d = ST_PASS;
        else if (ce_in_n) state_d = ST_LOCK;
        else if (expired) state_d = ST_LOCK;
      end
      ST_LOCK: begin
        if (!fail_s) state_d = ST_PASS;
      end
      default: state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PASS;
    else        state_q <= state_d;
  end

  // In a hold the held level is low and it ends as soon as the input rises,
  // so the output equals the input there as in pass mode.
  always_comb begin
    run      = (state_q == ST_HOLD);
    protect  = (state_q == ST_LOCK);
    ce_out_n = protect ? 1'b1 : ce_in_n;
  end
endmodule

// File: rtl/cewp_guard.sv
module cewp_guard #(
  parameter int HOLD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic pwr_fail,
  output logic ce_out_n,
  output logic protect
);
  logic rst_meta_q;
  logic rst_sync_n;
  logic fail_sync;
  logic tmr_load;
  logic tmr_run;
  logic tmr_expired;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cewp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pwr_fail),
    .q     (fail_sync)
  );

  cewp_timer #(.CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (tmr_load),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  cewp_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_in_n  (ce_in_n),
    .fail_s   (fail_sync),
    .expired  (tmr_expired),
    .load     (tmr_load),
    .run      (tmr_run),
    .ce_out_n (ce_out_n),
    .protect  (protect)
  );
endmodule

// File: rtl/cewp_guard_chk.sv
module cewp_guard_chk #(
  parameter int HOLD_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic ce_in_n,
  input logic fail_s,
  input logic ce_out_n,
  input logic protect
);
  localparam int CW = $clog2(HOLD_CYCLES + 4) + 1;
  localparam logic [CW-1:0] RUN_MAX = CW'(HOLD_CYCLES + 1);

  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_run <= '0;
    else if (fail_s && !ce_out_n) low_run <= (low_run == '1) ? low_run : low_run + 1'b1;
    else                         low_run <= '0;
  end

  AST_LOCK_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    protect |-> ce_out_n); // R8

  AST_PASS_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!fail_s) |-> (ce_out_n == ce_in_n)); // R2

  AST_IDLE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_s && ce_out_n && !protect) |=> protect); // R4

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && !fail_s) |=> !protect); // R9

  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RUN_MAX); // R7
endmodule

bind cewp_guard cewp_guard_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_in_n  (ce_in_n),
  .fail_s   (fail_sync),
  .ce_out_n (ce_out_n),
  .protect  (protect)
);

// File: tb/tb_cewp_guard.sv
module tb_cewp_guard;
  localparam int HOLD = 8;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk;
  logic rst_n;
  logic ce_in_n;
  logic pwr_fail;
  logic ce_out_n;
  logic protect;

  int n_checks = 0;
  int n_err    = 0;

  cewp_guard #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_in_n  (ce_in_n),
    .pwr_fail (pwr_fail),
    .ce_out_n (ce_out_n),
    .protect  (protect)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  // compares {ce_out_n, protect}
  task automatic check(input string req, input logic [1:0] exp);
    n_checks++;
    if ({ce_out_n, protect} !== exp) begin
      n_err++;
      $display("FAIL %s: actual={ce_out_n,protect}=%b expected=%b at %0t",
               req, {ce_out_n, protect}, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_in_n = 1'b1; pwr_fail = 1'b0;
    #3;
    check("R1 reset idle", 2'b10);
    ce_in_n = 1'b0; #1;
    check("R1 reset follows", 2'b00);
    cyc(3);
    rst_n = 1'b1;
    ce_in_n = 1'b1;
    cyc(4);
    check("R1 after release", 2'b10);
  endtask

  task automatic t_follow();
    for (int i = 0; i < 6; i++) begin
      ce_in_n = (i % 3) == 1;
      #1;
      check("R2 same cycle", {ce_in_n, 1'b0});
      cyc(1);
      check("R2 after edge", {ce_in_n, 1'b0});
    end
    ce_in_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_idle_fail();
    ce_in_n = 1'b1; pwr_fail = 1'b1;
    cyc(LAT - 1);
    check("R3 not yet acted", 2'b10);
    ce_in_n = 1'b0; #1;
    check("R3 still follows", 2'b00);
    ce_in_n = 1'b1;
    cyc(1);
    check("R4 idle lock", 2'b11);
    ce_in_n = 1'b0; #1;
    check("R8 input ignored", 2'b11);
    cyc(3);
    check("R8 stays locked", 2'b11);
    pwr_fail = 1'b0;
    cyc(LAT - 1);
    check("R9 lock before latency", 2'b11);
    cyc(1);
    check("R9 released", 2'b00);
    ce_in_n = 1'b1; #1;
    check("R9 follows again", 2'b10);
    cyc(1);
  endtask

  task automatic t_busy_release();
    ce_in_n = 1'b0; pwr_fail = 1'b1;
    cyc(LAT);
    check("R5 hold entered", 2'b00);
    cyc(2);
    check("R5 hold kept", 2'b00);
    ce_in_n = 1'b1; #1;
    check("R6 out rises same cycle", 2'b10);
    cyc(1);
    check("R6 lock next edge", 2'b11);
    ce_in_n = 1'b0; #1;
    check("R8 locked after release", 2'b11);
    pwr_fail = 1'b0;
    cyc(LAT);
    ce_in_n = 1'b1;
    cyc(1);
    check("R9 back to pass", 2'b10);
  endtask

  task automatic t_busy_timeout();
    ce_in_n = 1'b0; pwr_fail = 1'b1;
    cyc(LAT - 1 + HOLD);
    check("R7 last hold cycle", 2'b00);
    cyc(1);
    check("R7 timeout lock", 2'b11);
    pwr_fail = 1'b0;
    cyc(LAT);
    check("R9 release after timeout", 2'b00);
    ce_in_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_clear_in_hold();
    ce_in_n = 1'b0; pwr_fail = 1'b1;
    cyc(LAT + 1);
    check("R10 in hold", 2'b00);
    pwr_fail = 1'b0;
    cyc(LAT);
    ce_in_n = 1'b1; #1;
    check("R10 follows high", 2'b10);
    ce_in_n = 1'b0; #1;
    check("R10 follows low", 2'b00);
    cyc(HOLD + 2);
    check("R10 no timeout lock", 2'b00);
    ce_in_n = 1'b1;
    cyc(1);
    check("R10 pass high", 2'b10);
  endtask

  initial begin
    t_reset();
    t_follow();
    t_idle_fail();
    t_busy_release();
    t_busy_timeout();
    t_clear_in_hold();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end
endmodule